// File: doc/BRIEF.md
# Flash Command Sequencer with Embedded Byte Array

This block models, in synthesizable form, the command front end of a byte-wide flash memory together with a small on-chip storage array. Every bus write is fed to a sequence-matching state machine; only a complete and exact unlock-and-command sequence changes the array. The state machine supports three operations. Byte program can only clear bits. Sector erase fills one or more selected sectors with FFh. Chip erase fills the whole array with FFh.

The storage is split into eight equal sectors, picked by the top three bits of the array index. After a sector-erase command, the block keeps a short acceptance window open. During that window, further sector-erase writes add sectors to an 8-bit selection mask. While a program or erase is in progress, reads return a status byte instead of array data. The array size and all busy durations are parameters counted in clock cycles, so a simulation can run with short values. A low-supply input blocks every write. The block is meant as a device-side partner for checking a host-side sequencer.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset, `busy` is 0 and every array byte reads FFh.
- R2: The program sequence is AAh@5555h, then 55h@2AAAh, then A0h@5555h, then data@address. After the operation ends, the byte at that address holds the bitwise AND of its old value and the written data.
- R3: `busy` rises after the program data write and stays high for PROG_CYC cycles. During that time a read returns bit 7 equal to the complement of bit 7 of the written data, with bits 6..0 equal to 0.
- R4: The sector erase sequence is AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at any address inside the target sector. The sector is the array index bits [ARRAY_AW-1:ARRAY_AW-3]. When the erase ends, every byte of that sector reads FFh. Bytes in other sectors keep their values.
- R5: Further 30h writes made within WIN_CYC cycles of the first one add their sectors to the set. All the collected sectors are erased together.
- R6: The same erase prefix followed by 10h@5555h erases every byte in the array to FFh.
- R7: If any step of a sequence has a wrong address or a wrong data byte, the machine returns to read mode. A later data write then leaves the array unchanged.
- R8: Bus writes made while a program or erase is busy are ignored, including any unlock bytes among them.
- R9: While `supply_low` is 1, bus writes are ignored.
- R10: During the sector acceptance window and during an erase, a read returns 00h (the complement of bit 7 of FFh, with the low bits at 0).
- R11: A write other than 30h during the acceptance window cancels the erase. No byte is changed and the machine returns to read mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; fills the array with FFh |
| bus_we | input | 1 | One-cycle write strobe; one strobe is one bus write cycle |
| bus_addr | input | BUS_AW | Byte address for writes and reads |
| bus_wdata | input | 8 | Write data byte |
| supply_low | input | 1 | Low-supply lockout; blocks all writes while high |
| rd_data | output | 8 | Registered read data: array byte, or status while busy |
| busy | output | 1 | High during the acceptance window, program, or erase |

## Verification
The program path is driven from a vector table. The entries cover a first write into erased storage, a second write to the same byte with a pattern that only partly overlaps, and data with bit 7 both set and clear. Together they separate a true AND from a plain overwrite, and they show that the status complement follows bit 7 of the data. The erase patterns use a single sector, two sectors collected in one window, and the whole array. Bytes in sectors that were not chosen are read back, so an erase that spreads into the wrong sectors is exposed. Rejection patterns cover a wrong unlock address, a wrong command byte, writes during busy, writes under lockout, and an aborted window. Each is followed by a data write that would change the array if the machine had accepted the step.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

  // Unlock key addresses and bytes
  localparam logic [14:0] KEY_ADDR_A   = 15'h5555;
  localparam logic [14:0] KEY_ADDR_B   = 15'h2AAA;
  localparam logic [7:0]  KEY_BYTE_A   = 8'hAA;
  localparam logic [7:0]  KEY_BYTE_B   = 8'h55;

  // Command bytes
  localparam logic [7:0]  OP_PROGRAM   = 8'hA0;
  localparam logic [7:0]  OP_ERASE_PFX = 8'h80;
  localparam logic [7:0]  OP_ERASE_ALL = 8'h10;
  localparam logic [7:0]  OP_ERASE_SEC = 8'h30;

  typedef enum logic [3:0] {
    S_IDLE,
    S_KEY1,
    S_KEY2,
    S_PGM_DATA,
    S_ERA_PFX,
    S_ERA_KEY1,
    S_ERA_KEY2,
    S_SECT_WIN,
    S_PGM_BUSY,
    S_ERA_BUSY
  } seq_state_t;

  // A program can only clear bits
  function automatic logic [7:0] merge_program(input logic [7:0] old_b,
                                               input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  // Status byte shown while busy: inverted target bit 7, low bits zero
  function automatic logic [7:0] status_byte(input logic tgt7);
    return {~tgt7, 7'b000_0000};
  endfunction

endpackage

// File: rtl/fcmd_timer.sv
module fcmd_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  assign done = (cnt_q == CW'(1));

  AST_TMR_DONE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> (cnt_q == '0)); // R3

endmodule

// File: rtl/fcmd_seq.sv
module fcmd_seq
  import fcmd_pkg::*;
#(
  parameter int BUS_AW    = 16,
  parameter int ARRAY_AW  = 9,
  parameter int SECT_N    = 8,
  parameter int CW        = 5,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 20,
  parameter int WIN_CYC   = 6,
  localparam int SW       = $clog2(SECT_N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic                lockout,
  input  logic [BUS_AW-1:0]   addr,
  input  logic [7:0]          wdata,
  input  logic [ARRAY_AW-1:0] arr_idx,
  input  logic [SW-1:0]       sect_idx,
  input  logic                tmr_done,
  output logic                tmr_load,
  output logic [CW-1:0]       tmr_val,
  output logic                commit_prog,
  output logic                commit_erase,
  output logic [ARRAY_AW-1:0] prog_idx,
  output logic [7:0]          prog_data,
  output logic [SECT_N-1:0]   erase_mask,
  output logic                busy,
  output logic                tgt7
);

  seq_state_t          st_q, st_n;
  logic [ARRAY_AW-1:0] pa_q, pa_n;
  logic [7:0]          pd_q, pd_n;
  logic [SECT_N-1:0]   mask_q, mask_n;

  // Named events used by the transitions and the assertions
  logic wr, at_a, at_b, step_key1, step_key2;
  logic [SECT_N-1:0] sect_bit;

  assign wr        = we && !lockout;
  assign at_a      = (addr == BUS_AW'(KEY_ADDR_A));
  assign at_b      = (addr == BUS_AW'(KEY_ADDR_B));
  assign step_key1 = wr && at_a && (wdata == KEY_BYTE_A);
  assign step_key2 = wr && at_b && (wdata == KEY_BYTE_B);
  assign sect_bit  = SECT_N'(1) << sect_idx;

  always_comb begin
    st_n         = st_q;
    pa_n         = pa_q;
    pd_n         = pd_q;
    mask_n       = mask_q;
    tmr_load     = 1'b0;
    tmr_val      = '0;
    commit_prog  = 1'b0;
    commit_erase = 1'b0;
    case (st_q)
      S_IDLE:     if (wr) st_n = step_key1 ? S_KEY1 : S_IDLE;
      S_KEY1:     if (wr) st_n = step_key2 ? S_KEY2 : S_IDLE;
      S_KEY2: if (wr) begin
        if (at_a && wdata == OP_PROGRAM)        st_n = S_PGM_DATA;
        else if (at_a && wdata == OP_ERASE_PFX) st_n = S_ERA_PFX;
        else                                    st_n = S_IDLE;
      end
      S_PGM_DATA: if (wr) begin
        st_n     = S_PGM_BUSY;
        pa_n     = arr_idx;
        pd_n     = wdata;
        tmr_load = 1'b1;
        tmr_val  = CW'(PROG_CYC);
      end
      S_ERA_PFX:  if (wr) st_n = step_key1 ? S_ERA_KEY1 : S_IDLE;
      S_ERA_KEY1: if (wr) st_n = step_key2 ? S_ERA_KEY2 : S_IDLE;
      S_ERA_KEY2: if (wr) begin
        if (at_a && wdata == OP_ERASE_ALL) begin
          st_n     = S_ERA_BUSY;
          mask_n   = '1;
          tmr_load = 1'b1;
          tmr_val  = CW'(ERASE_CYC);
        end else if (wdata == OP_ERASE_SEC) begin
          st_n     = S_SECT_WIN;
          mask_n   = sect_bit;
          tmr_load = 1'b1;
          tmr_val  = CW'(WIN_CYC);
        end else begin
          st_n     = S_IDLE;
        end
      end
      S_SECT_WIN: begin
        if (wr && wdata != OP_ERASE_SEC) begin
          st_n   = S_IDLE;
          mask_n = '0;
        end else begin
          if (wr) mask_n = mask_q | sect_bit;
          if (tmr_done) begin
            st_n     = S_ERA_BUSY;
            tmr_load = 1'b1;
            tmr_val  = CW'(ERASE_CYC);
          end
        end
      end
      S_PGM_BUSY: if (tmr_done) begin
        commit_prog = 1'b1;
        st_n        = S_IDLE;
      end
      S_ERA_BUSY: if (tmr_done) begin
        commit_erase = 1'b1;
        st_n         = S_IDLE;
      end
      default:    st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      pa_q   <= '0;
      pd_q   <= 8'hFF;
      mask_q <= '0;
    end else begin
      st_q   <= st_n;
      pa_q   <= pa_n;
      pd_q   <= pd_n;
      mask_q <= mask_n;
    end
  end

  assign prog_idx   = pa_q;
  assign prog_data  = pd_q;
  assign erase_mask = mask_q;
  assign busy       = (st_q == S_SECT_WIN) || (st_q == S_PGM_BUSY) || (st_q == S_ERA_BUSY);
  assign tgt7       = (st_q == S_PGM_BUSY) ? pd_q[7] : 1'b1;

  AST_BAD_KEY_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_KEY1 && wr && !step_key2) |=> (st_q == S_IDLE)); // R7

  AST_LOCKOUT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (lockout && !tmr_done) |=> $stable(st_q)); // R9

  AST_PGM_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_PGM_BUSY && !tmr_done) |=> (st_q == S_PGM_BUSY && $stable(pd_q))); // R8

  AST_WIN_ABORT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_SECT_WIN && wr && wdata != OP_ERASE_SEC) |=> (st_q == S_IDLE && mask_q == '0)); // R11

  AST_COMMIT_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit_prog, commit_erase, tmr_load})); // R2

endmodule

// File: rtl/fcmd_array.sv
module fcmd_array
  import fcmd_pkg::*;
#(
  parameter int ARRAY_AW = 9,
  parameter int SECT_N   = 8,
  localparam int DEPTH   = 1 << ARRAY_AW,
  localparam int SW      = $clog2(SECT_N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ARRAY_AW-1:0] ridx,
  input  logic                commit_prog,
  input  logic [ARRAY_AW-1:0] prog_idx,
  input  logic [7:0]          prog_data,
  input  logic                commit_erase,
  input  logic [SECT_N-1:0]   erase_mask,
  input  logic                status_mode,
  input  logic                tgt7,
  output logic [7:0]          rd_data
);

  logic [7:0] mem_q [DEPTH];
  logic [7:0] rd_q;
  logic [7:0] old_byte;

  function automatic logic [SW-1:0] sect_of(input logic [ARRAY_AW-1:0] a);
    return a[ARRAY_AW-1 -: SW];
  endfunction

  assign old_byte = mem_q[prog_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (commit_prog) begin
      mem_q[prog_idx] <= merge_program(old_byte, prog_data);
    end else if (commit_erase) begin
      for (int i = 0; i < DEPTH; i++)
        if (erase_mask[sect_of(ARRAY_AW'(i))]) mem_q[i] <= 8'hFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rd_q <= 8'hFF;
    else if (status_mode) rd_q <= status_byte(tgt7);
    else                  rd_q <= mem_q[ridx];
  end

  assign rd_data = rd_q;

  AST_PROG_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    commit_prog |=> ((mem_q[$past(prog_idx)] & ~$past(old_byte)) == 8'h00)); // R2

  AST_STATUS_BIT7_INV: assert property (@(posedge clk) disable iff (!rst_n)
    status_mode |=> (rd_q[7] != $past(tgt7))); // R3

endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine #(
  parameter int BUS_AW    = 16,
  parameter int ARRAY_AW  = 9,
  parameter int SECT_N    = 8,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 20,
  parameter int WIN_CYC   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              supply_low,
  output logic [7:0]        rd_data,
  output logic              busy
);

  localparam int SW      = $clog2(SECT_N);
  localparam int MAX_PE  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int MAX_CYC = (MAX_PE > WIN_CYC) ? MAX_PE : WIN_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic [ARRAY_AW-1:0] arr_idx;
  logic [SW-1:0]       sect_idx;
  logic                tmr_load, tmr_done;
  logic [CW-1:0]       tmr_val;
  logic                commit_prog, commit_erase;
  logic [ARRAY_AW-1:0] prog_idx;
  logic [7:0]          prog_data;
  logic [SECT_N-1:0]   erase_mask;
  logic                tgt7;

  assign arr_idx  = bus_addr[ARRAY_AW-1:0];
  assign sect_idx = bus_addr[ARRAY_AW-1 -: SW];

  fcmd_seq #(
    .BUS_AW(BUS_AW), .ARRAY_AW(ARRAY_AW), .SECT_N(SECT_N), .CW(CW),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .WIN_CYC(WIN_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .lockout(supply_low),
    .addr(bus_addr), .wdata(bus_wdata), .arr_idx(arr_idx), .sect_idx(sect_idx),
    .tmr_done(tmr_done), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .commit_prog(commit_prog), .commit_erase(commit_erase),
    .prog_idx(prog_idx), .prog_data(prog_data), .erase_mask(erase_mask),
    .busy(busy), .tgt7(tgt7)
  );

  fcmd_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  fcmd_array #(.ARRAY_AW(ARRAY_AW), .SECT_N(SECT_N)) u_array (
    .clk(clk), .rst_n(rst_n), .ridx(arr_idx),
    .commit_prog(commit_prog), .prog_idx(prog_idx), .prog_data(prog_data),
    .commit_erase(commit_erase), .erase_mask(erase_mask),
    .status_mode(busy), .tgt7(tgt7), .rd_data(rd_data)
  );

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !busy); // R1

endmodule

// File: tb/test_flash_cmd_engine.sv
module test_flash_cmd_engine;

  localparam int PROG_CYC  = 8;
  localparam int ERASE_CYC = 20;
  localparam int WIN_CYC   = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        supply_low = 1'b0;
  logic [7:0]  rd_data;
  logic        busy;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  flash_cmd_engine #(
    .BUS_AW(16), .ARRAY_AW(9), .SECT_N(8),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .WIN_CYC(WIN_CYC)
  ) i_flash_cmd_engine (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .supply_low(supply_low), .rd_data(rd_data), .busy(busy)
  );

  // {array index, program data, expected byte afterwards}
  localparam logic [24:0] PGM_VEC [6] = '{
    {9'h010, 8'h5A, 8'h5A},
    {9'h010, 8'h0F, 8'h0A},
    {9'h1FF, 8'h80, 8'h80},
    {9'h000, 8'h00, 8'h00},
    {9'h0C3, 8'h3C, 8'h3C},
    {9'h010, 8'hF0, 8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [8:0] idx, output logic [7:0] d);
    @(negedge clk);
    bus_addr = {7'b0, idx};
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic do_program(input logic [8:0] idx, input logic [7:0] d);
    bus_write(16'h5555, 8'hAA);
    bus_write(16'h2AAA, 8'h55);
    bus_write(16'h5555, 8'hA0);
    bus_write({7'b0, idx}, d);
  endtask

  task automatic erase_prefix();
    bus_write(16'h5555, 8'hAA);
    bus_write(16'h2AAA, 8'h55);
    bus_write(16'h5555, 8'h80);
    bus_write(16'h5555, 8'hAA);
    bus_write(16'h2AAA, 8'h55);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    idle(3);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 busy after reset", {7'b0, busy}, 8'h00);
    bus_read(9'h000, v); chk("R1 byte 000", v, 8'hFF);
    bus_read(9'h1FF, v); chk("R1 byte 1FF", v, 8'hFF);
    bus_read(9'h0AB, v); chk("R1 byte 0AB", v, 8'hFF);

    // R2/R3 table of program vectors
    for (int n = 0; n < 6; n++) begin
      logic [8:0] a; logic [7:0] d, e;
      {a, d, e} = PGM_VEC[n];
      do_program(a, d);
      chk("R3 busy after data write", {7'b0, busy}, 8'h01);
      bus_read(a, v); chk("R3 status byte", v, {~d[7], 7'b0});
      idle(PROG_CYC + 2);
      chk("R3 busy ended", {7'b0, busy}, 8'h00);
      bus_read(a, v); chk("R2 programmed byte", v, e);
    end

    // R7 wrong address in second unlock step
    bus_write(16'h5555, 8'hAA);
    bus_write(16'h2AAB, 8'h55);
    bus_write(16'h5555, 8'hA0);
    bus_write(16'h00AB, 8'h00);
    chk("R7 no busy after bad address", {7'b0, busy}, 8'h00);
    bus_read(9'h0AB, v); chk("R7 bad address leaves byte", v, 8'hFF);
    // R7 wrong command byte
    bus_write(16'h5555, 8'hAA);
    bus_write(16'h2AAA, 8'h55);
    bus_write(16'h5555, 8'hA1);
    bus_write(16'h00AB, 8'h00);
    bus_read(9'h0AB, v); chk("R7 bad command leaves byte", v, 8'hFF);

    // R8 unlock byte written during program busy is dropped
    do_program(9'h020, 8'h77);
    bus_write(16'h5555, 8'hAA);
    idle(PROG_CYC + 2);
    bus_write(16'h2AAA, 8'h55);
    bus_write(16'h5555, 8'hA0);
    bus_write(16'h0020, 8'h00);
    chk("R8 no new busy", {7'b0, busy}, 8'h00);
    bus_read(9'h020, v); chk("R8 byte kept", v, 8'h77);

    // R9 lockout blocks a full program sequence
    supply_low = 1'b1;
    do_program(9'h030, 8'h00);
    chk("R9 no busy under lockout", {7'b0, busy}, 8'h00);
    supply_low = 1'b0;
    bus_read(9'h030, v); chk("R9 byte unchanged", v, 8'hFF);

    // R11 aborted acceptance window
    erase_prefix();
    bus_write(16'h0005, 8'h30);
    bus_write(16'h0000, 8'h00);
    idle(WIN_CYC + ERASE_CYC + 4);
    chk("R11 busy cleared", {7'b0, busy}, 8'h00);
    bus_read(9'h020, v); chk("R11 sector 0 kept", v, 8'h77);

    // R4/R10 single sector erase (sector 0)
    erase_prefix();
    bus_write(16'h0020, 8'h30);
    chk("R10 busy in window", {7'b0, busy}, 8'h01);
    bus_read(9'h0C3, v); chk("R10 status in window", v, 8'h00);
    idle(WIN_CYC + ERASE_CYC + 4);
    chk("R4 busy ended", {7'b0, busy}, 8'h00);
    bus_read(9'h010, v); chk("R4 byte 010 erased", v, 8'hFF);
    bus_read(9'h020, v); chk("R4 byte 020 erased", v, 8'hFF);
    bus_read(9'h000, v); chk("R4 byte 000 erased", v, 8'hFF);
    bus_read(9'h0C3, v); chk("R4 sector 3 kept", v, 8'h3C);
    bus_read(9'h1FF, v); chk("R4 sector 7 kept", v, 8'h80);

    // R5 two sectors collected in one window
    do_program(9'h005, 8'h11);
    idle(PROG_CYC + 2);
    erase_prefix();
    bus_write(16'h0005, 8'h30);
    bus_write(16'h00C0, 8'h30);
    idle(WIN_CYC);
    chk("R10 busy in erase", {7'b0, busy}, 8'h01);
    bus_read(9'h005, v); chk("R10 status in erase", v, 8'h00);
    idle(ERASE_CYC + 4);
    bus_read(9'h005, v); chk("R5 sector 0 erased", v, 8'hFF);
    bus_read(9'h0C3, v); chk("R5 sector 3 erased", v, 8'hFF);
    bus_read(9'h1FF, v); chk("R5 sector 7 kept", v, 8'h80);

    // R6 chip erase
    do_program(9'h100, 8'h12);
    idle(PROG_CYC + 2);
    erase_prefix();
    bus_write(16'h5555, 8'h10);
    chk("R6 busy in chip erase", {7'b0, busy}, 8'h01);
    idle(ERASE_CYC + 4);
    bus_read(9'h1FF, v); chk("R6 byte 1FF erased", v, 8'hFF);
    bus_read(9'h100, v); chk("R6 byte 100 erased", v, 8'hFF);

    finish_run();
  end

endmodule